// File: doc/BRIEF.md
# Video Blanking Line and Frame Sequencer

This block watches the horizontal and vertical blanking signals of a live video stream, all in the pixel clock domain, and turns them into the counters and strobes that a downstream scaler needs. A pixel counter and a line-buffer write pointer start again on every line. A line counter advances once per line, and its value is decoded to open and close a processing window inside the active frame. A single-cycle frame reset is placed a programmable number of lines into vertical blanking. Firing at the blanking edge would be too early for logic that still carries several lines of latency.

A configuration write loads three values: the frame-reset line, the window start line and the window end line. The same write clears a sticky timing-error flag. That flag is raised when a horizontal blanking pulse, or the active gap between two pulses, is shorter than the minimum the scaler needs.

Top module: `blank_line_sequencer`

## Requirements
- R1: When hBlank is 1 at a clock edge, pixelCount and wrAddr are both 0 after that edge.
- R2: When hBlank is 0 at a clock edge, pixelCount and wrAddr each grow by one at that edge (modulo their widths), so after N low cycles following blanking both read N.
- R3: activeVideo is the inverse of hBlank as sampled at the previous clock edge.
- R4: lineCount grows by one at each edge where hBlank is 1 after having been 0 at the previous edge, provided vBlank did not change.
- R5: lineCount becomes 0 at any edge where vBlank differs from its value at the previous edge, rising or falling; this clear wins over an increment in the same cycle.
- R6: windowOpen goes to 1 the cycle after lineCount equals the start line while vBlank is 0, and goes to 0 the cycle after lineCount equals the end line (end checked first); it is 0 the cycle after any edge where vBlank is 1 or vBlank changed.
- R7: frameReset is a one-cycle pulse, issued the cycle after the hBlank rise inside vertical blanking that brings lineCount to the configured frame-reset line; it fires at most once per vertical blanking period, never when that line is 0, and not at all when vertical blanking ends first.
- R8: timingError is set when a complete hBlank high run lasts fewer than 100 cycles or a complete low run fewer than 32 cycles (runs are judged from the second hBlank transition after reset), and stays set.
- R9: A cycle with cfgWrite at 1 loads the three configuration values for use from the next cycle and clears timingError, unless a timing violation is detected in that same cycle.
- R10: A cycle with rst at 1 clears pixelCount, wrAddr, lineCount, windowOpen, frameReset and timingError.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hBlank | input | 1 | Horizontal blanking |
| vBlank | input | 1 | Vertical blanking |
| cfgWrite | input | 1 | Load configuration, clear error flag |
| cfgFrameLine | input | LINE_W | Frame-reset line within vertical blanking (0 disables) |
| cfgWinStart | input | LINE_W | Line at which the window opens |
| cfgWinEnd | input | LINE_W | Line at which the window closes |
| pixelCount | output | PIX_W | Pixel position in the active line |
| wrAddr | output | ADDR_W | Line-buffer write pointer |
| lineCount | output | LINE_W | Line counter |
| activeVideo | output | 1 | Registered inverse of hBlank |
| windowOpen | output | 1 | Processing window state |
| frameReset | output | 1 | One-cycle frame reset pulse |
| timingError | output | 1 | Sticky blanking timing error |

## Verification
The main sequence walks whole lines, each with its own blanking length, active length and vertical blanking level. It covers lines of exactly minimum and longer length, a run of active lines through the window start and end, and a blanking period long enough for the frame reset, so that the pixel count, the line count, the window state and the frame pulse can each be told apart from an off-by-one. Directed cases then use vertical blanking that ends before the frame-reset line, a frame-reset line of zero, a low run shorter than the minimum, a falling vertical edge in the middle of a line, and a reset in the middle of a line. These separate the edge-priority and sticky-flag rules from the plain counting.

// File: rtl/blank_seq_pkg.sv
package blank_seq_pkg;
  // strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic pixHold;   // hold pixel counter and write pointer at zero
    logic lineClr;   // clear line counter
    logic lineInc;   // advance line counter
    logic winClr;    // force window closed
  } seqStrobes_t;
endpackage

// File: rtl/blank_seq_ctrl.sv
module blank_seq_ctrl
  import blank_seq_pkg::*;
#(
  parameter int MIN_HI = 100,
  parameter int MIN_LO = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hBlank,
  input  logic        vBlank,
  input  logic        cfgWrite,
  input  logic        frameHit,
  output seqStrobes_t strobes,
  output logic        activeVideo,
  output logic        frameReset,
  output logic        timingError
);
  localparam int RUN_MAX = (MIN_HI > MIN_LO) ? MIN_HI : MIN_LO;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(RUN_MAX);
  localparam logic [RUN_W-1:0] HI_LIM  = RUN_W'(MIN_HI);
  localparam logic [RUN_W-1:0] LO_LIM  = RUN_W'(MIN_LO);

  logic hQ, vQ;
  logic hEdge, hRise, vEdge;
  logic [RUN_W-1:0] runLen;
  logic runValid;
  logic violate;
  logic firedThisBlank;
  logic fireNow;

  // registered copies of the blanking inputs
  always_ff @(posedge clk) begin
    if (rst) begin
      hQ <= 1'b0;
      vQ <= 1'b0;
    end else begin
      hQ <= hBlank;
      vQ <= vBlank;
    end
  end

  assign hEdge = hBlank ^ hQ;
  assign hRise = hBlank & ~hQ;
  assign vEdge = vBlank ^ vQ;

  always_comb begin
    strobes.pixHold = hBlank;
    strobes.lineClr = vEdge;
    strobes.lineInc = hRise;
    strobes.winClr  = vBlank | vEdge;
  end

  assign activeVideo = ~hQ;

  // run-length measurement of the blanking high and low phases
  always_ff @(posedge clk) begin
    if (rst) begin
      runLen   <= '0;
      runValid <= 1'b0;
    end else if (hEdge) begin
      runLen   <= RUN_W'(1);
      runValid <= 1'b1;
    end else if (runLen < RUN_SAT) begin
      runLen <= runLen + RUN_W'(1);
    end
  end

  always_comb begin
    violate = 1'b0;
    if (hEdge && runValid) begin
      if (hQ) violate = (runLen < HI_LIM);
      else    violate = (runLen < LO_LIM);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           timingError <= 1'b0;
    else if (violate)  timingError <= 1'b1;
    else if (cfgWrite) timingError <= 1'b0;
  end

  // frame reset: one pulse per vertical blanking period
  assign fireNow = hRise & vBlank & ~vEdge & frameHit & ~firedThisBlank;

  always_ff @(posedge clk) begin
    if (rst) begin
      frameReset     <= 1'b0;
      firedThisBlank <= 1'b0;
    end else begin
      frameReset <= fireNow;
      if (!vBlank || vEdge) firedThisBlank <= 1'b0;
      else if (fireNow)     firedThisBlank <= 1'b1;
    end
  end
endmodule

// File: rtl/blank_seq_datapath.sv
module blank_seq_datapath
  import blank_seq_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int ADDR_W = 11,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic              cfgWrite,
  input  logic [LINE_W-1:0] cfgFrameLine,
  input  logic [LINE_W-1:0] cfgWinStart,
  input  logic [LINE_W-1:0] cfgWinEnd,
  output logic [PIX_W-1:0]  pixelCount,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LINE_W-1:0] lineCount,
  output logic              windowOpen,
  output logic              frameHit
);
  logic [LINE_W-1:0] frameLineReg, winStartReg, winEndReg;
  logic [LINE_W-1:0] lineNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      frameLineReg <= '0;
      winStartReg  <= '0;
      winEndReg    <= '0;
    end else if (cfgWrite) begin
      frameLineReg <= cfgFrameLine;
      winStartReg  <= cfgWinStart;
      winEndReg    <= cfgWinEnd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobes.pixHold) begin
      pixelCount <= '0;
      wrAddr     <= '0;
    end else begin
      pixelCount <= pixelCount + PIX_W'(1);
      wrAddr     <= wrAddr + ADDR_W'(1);
    end
  end

  assign lineNext = lineCount + LINE_W'(1);

  always_ff @(posedge clk) begin
    if (rst || strobes.lineClr) lineCount <= '0;
    else if (strobes.lineInc)   lineCount <= lineNext;
  end

  // line match against the frame-reset line, 0 disables
  assign frameHit = (frameLineReg != '0) && (lineNext == frameLineReg);

  always_ff @(posedge clk) begin
    if (rst || strobes.winClr)          windowOpen <= 1'b0;
    else if (lineCount == winEndReg)    windowOpen <= 1'b0;
    else if (lineCount == winStartReg)  windowOpen <= 1'b1;
  end
endmodule

// File: rtl/blank_line_sequencer.sv
module blank_line_sequencer
  import blank_seq_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int ADDR_W = 11,
  parameter int LINE_W = 11,
  parameter int MIN_HI = 100,
  parameter int MIN_LO = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hBlank,
  input  logic              vBlank,
  input  logic              cfgWrite,
  input  logic [LINE_W-1:0] cfgFrameLine,
  input  logic [LINE_W-1:0] cfgWinStart,
  input  logic [LINE_W-1:0] cfgWinEnd,
  output logic [PIX_W-1:0]  pixelCount,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LINE_W-1:0] lineCount,
  output logic              activeVideo,
  output logic              windowOpen,
  output logic              frameReset,
  output logic              timingError
);
  seqStrobes_t strobes;
  logic        frameHit;

  blank_seq_ctrl #(.MIN_HI(MIN_HI), .MIN_LO(MIN_LO)) ctrl (
    .clk(clk), .rst(rst), .hBlank(hBlank), .vBlank(vBlank),
    .cfgWrite(cfgWrite), .frameHit(frameHit), .strobes(strobes),
    .activeVideo(activeVideo), .frameReset(frameReset),
    .timingError(timingError)
  );

  blank_seq_datapath #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) dp (
    .clk(clk), .rst(rst), .strobes(strobes), .cfgWrite(cfgWrite),
    .cfgFrameLine(cfgFrameLine), .cfgWinStart(cfgWinStart),
    .cfgWinEnd(cfgWinEnd), .pixelCount(pixelCount), .wrAddr(wrAddr),
    .lineCount(lineCount), .windowOpen(windowOpen), .frameHit(frameHit)
  );
endmodule

// File: rtl/blank_line_sequencer_chk.sv
module blank_line_sequencer_chk #(
  parameter int PIX_W  = 12,
  parameter int ADDR_W = 11,
  parameter int LINE_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              hBlank,
  input logic              vBlank,
  input logic              cfgWrite,
  input logic [PIX_W-1:0]  pixelCount,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [LINE_W-1:0] lineCount,
  input logic              activeVideo,
  input logic              windowOpen,
  input logic              frameReset,
  input logic              timingError
);
  AST_PIX_HELD: assert property (@(posedge clk) disable iff (rst)
    hBlank |=> (pixelCount == '0 && wrAddr == '0)); // R1
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (rst)
    !hBlank |=> (pixelCount == $past(pixelCount) + PIX_W'(1))); // R2
  AST_ACTIVE_INV: assert property (@(posedge clk) disable iff (rst)
    hBlank |=> !activeVideo); // R3
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
    (hBlank && !$past(hBlank) && vBlank == $past(vBlank))
      |=> (lineCount == $past(lineCount) + LINE_W'(1))); // R4
  AST_LINE_CLR: assert property (@(posedge clk) disable iff (rst)
    (vBlank != $past(vBlank)) |=> (lineCount == '0)); // R5
  AST_WIN_CLOSED: assert property (@(posedge clk) disable iff (rst)
    vBlank |=> !windowOpen); // R6
  AST_FRAME_ONE: assert property (@(posedge clk) disable iff (rst)
    frameReset |=> !frameReset); // R7
  AST_FRAME_VB: assert property (@(posedge clk) disable iff (rst)
    frameReset |-> $past(vBlank)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (timingError && !cfgWrite) |=> timingError); // R8
endmodule

bind blank_line_sequencer blank_line_sequencer_chk #(
  .PIX_W(PIX_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W)
) chk (.*);

// File: tb/blank_line_sequencer_test.sv
module blank_line_sequencer_test;
  localparam int PIX_W = 12, ADDR_W = 11, LINE_W = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hBlank = 1'b0, vBlank = 1'b0, cfgWrite = 1'b0;
  logic [LINE_W-1:0] cfgFrameLine = '0, cfgWinStart = '0, cfgWinEnd = '0;
  logic [PIX_W-1:0]  pixelCount;
  logic [ADDR_W-1:0] wrAddr;
  logic [LINE_W-1:0] lineCount;
  logic activeVideo, windowOpen, frameReset, timingError;

  int checks = 0, fails = 0, frCount = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  blank_line_sequencer uut (
    .clk(clk), .rst(rst), .hBlank(hBlank), .vBlank(vBlank),
    .cfgWrite(cfgWrite), .cfgFrameLine(cfgFrameLine),
    .cfgWinStart(cfgWinStart), .cfgWinEnd(cfgWinEnd),
    .pixelCount(pixelCount), .wrAddr(wrAddr), .lineCount(lineCount),
    .activeVideo(activeVideo), .windowOpen(windowOpen),
    .frameReset(frameReset), .timingError(timingError)
  );

  always @(negedge clk) if (!rst && frameReset) frCount++;

  // columns: vBlank, high cycles, low cycles, line, window, error, frame pulses
  localparam int NV = 13;
  localparam int VEC [0:NV-1][0:6] = '{
    '{0, 100, 40, 1, 0, 0, 0},
    '{0, 120, 32, 2, 0, 0, 0},
    '{0, 100, 50, 3, 1, 0, 0},
    '{0, 100, 33, 4, 1, 0, 0},
    '{0, 100, 64, 5, 1, 0, 0},
    '{0, 100, 40, 6, 0, 0, 0},
    '{1, 100, 40, 0, 0, 0, 0},
    '{1, 100, 40, 1, 0, 0, 0},
    '{1, 100, 40, 2, 0, 0, 1},
    '{1, 100, 40, 3, 0, 0, 1},
    '{0, 100, 40, 0, 0, 0, 1},
    '{0, 100, 40, 1, 0, 0, 1},
    '{0,  99, 40, 2, 0, 1, 1}
  };

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic writeCfg(input int fl, input int ws, input int we);
    cfgFrameLine = LINE_W'(fl);
    cfgWinStart  = LINE_W'(ws);
    cfgWinEnd    = LINE_W'(we);
    cfgWrite     = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic runLine(input int hi, input int lo);
    hBlank = 1'b1;
    repeat (hi) @(negedge clk);
    hBlank = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 pixelCount", int'(pixelCount), 0);
    check("R10 lineCount", int'(lineCount), 0);
    check("R10 windowOpen", int'(windowOpen), 0);
    check("R10 frameReset", int'(frameReset), 0);
    check("R10 timingError", int'(timingError), 0);
    rst = 1'b0;
    @(negedge clk);
    writeCfg(2, 3, 6);
    repeat (40) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vBlank = VEC[i][0][0];
      runLine(VEC[i][1], VEC[i][2]);
      check($sformatf("R2 pixelCount line %0d", i), int'(pixelCount), VEC[i][2]);
      check($sformatf("R2 wrAddr line %0d", i), int'(wrAddr), VEC[i][2]);
      check($sformatf("R3 activeVideo line %0d", i), int'(activeVideo), 1);
      check($sformatf("R4 R5 lineCount line %0d", i), int'(lineCount), VEC[i][3]);
      check($sformatf("R6 windowOpen line %0d", i), int'(windowOpen), VEC[i][4]);
      check($sformatf("R8 timingError line %0d", i), int'(timingError), VEC[i][5]);
      check($sformatf("R7 frame pulses line %0d", i), frCount, VEC[i][6]);
    end

    // R9 configuration write clears the error flag
    writeCfg(5, 3, 6);
    check("R9 error cleared", int'(timingError), 0);

    // R7 vertical blanking ends before the frame-reset line
    vBlank = 1'b1;
    repeat (3) runLine(100, 40);
    vBlank = 1'b0;
    runLine(100, 40);
    check("R7 short blanking no pulse", frCount, 1);

    // R7 frame-reset line 0 disables
    writeCfg(0, 3, 6);
    vBlank = 1'b1;
    repeat (6) runLine(100, 40);
    vBlank = 1'b0;
    runLine(100, 40);
    check("R7 zero line no pulse", frCount, 1);

    // R7 one pulse only, even over a long blanking period
    writeCfg(1, 3, 6);
    vBlank = 1'b1;
    repeat (5) runLine(100, 40);
    check("R7 single pulse", frCount, 2);
    vBlank = 1'b0;
    runLine(100, 40);

    // R8 short low run
    runLine(100, 10);
    runLine(100, 40);
    check("R8 short low run", int'(timingError), 1);

    // R5 falling vertical edge mid-line clears the line count
    vBlank = 1'b1;
    runLine(100, 40);
    runLine(100, 20);
    check("R4 lineCount in blanking", int'(lineCount), 1);
    vBlank = 1'b0;
    @(negedge clk);
    check("R5 falling edge clear", int'(lineCount), 0);
    repeat (20) @(negedge clk);

    // R1 and R3 inside blanking
    hBlank = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pixelCount held", int'(pixelCount), 0);
    check("R1 wrAddr held", int'(wrAddr), 0);
    check("R3 activeVideo low", int'(activeVideo), 0);
    repeat (100) @(negedge clk);
    hBlank = 1'b0;
    repeat (10) @(negedge clk);

    // R10 reset mid-line
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid-line pixelCount", int'(pixelCount), 0);
    check("R10 mid-line lineCount", int'(lineCount), 0);
    check("R10 mid-line error", int'(timingError), 0);
    rst = 1'b0;

    finished = 1'b1;
    summary();
  end
endmodule